// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits on an APB-style register bus. Each pin can be made an input or an output through a direction register. The pin state is reached through a data window in which the word address itself selects the pins. Address bits [9:2] form a per-pin mask. A read returns only the pins whose mask bit is set, and every other bit reads as zero. A write changes only the masked pins.

Because of this addressing, software can drive or sample one pin through a dedicated address without a read-modify-write. Pin n alone sits at byte offset 1 << (n+2). Input pins cross into the bus clock domain through a two-flop synchronizer before they can be read. A chip that needs more pins places several copies, each at its own base address.

Top module: `gpio_masked_port`

## Requirements
- R1: While presetn is low at a rising edge of pclk, the direction register and the output data register clear to 0. Afterwards pin_oe and pin_out are 0 and the direction register reads 0.
- R2: The direction register sits at byte offset 0x400. A write stores pwdata[7:0], and a read returns it in prdata[7:0] with prdata[31:8] = 0. A 1 in bit n makes pin n an output.
- R3: pin_oe equals the direction register, and pin_out equals the output data register, for every pin, whether or not that pin is an output.
- R4: Any access with paddr[11:10] = 0 targets the data window, and paddr[9:2] is the mask. On a write, output bit n takes pwdata[n] when mask bit n is 1 and keeps its value when mask bit n is 0. A mask of 0 changes nothing.
- R5: On a data-window read, prdata bit n is 0 wherever mask bit n is 0, whatever the pin level. prdata[31:8] is always 0.
- R6: On a data-window read, an input pin (direction bit 0) returns its pin_in level after two pclk rising edges. A change on pin_in is not visible after one edge, and is visible after two.
- R7: On a data-window read, an output pin (direction bit 1) returns its output register bit and ignores pin_in.
- R8: Byte offset 1 << (n+2) reaches pin n alone. Writing 1 << n there drives only pin n high, writing 0 drives only pin n low, and a read returns only bit n.
- R9: Any other offset (not the data window, not 0x400) reads as 0, and a write there changes neither pin_out nor pin_oe.
- R10: pready is always 1 and pslverr is always 0.
- R11: A register changes only on an access-phase write (psel, penable and pwrite all 1). A setup-phase cycle, or penable without psel, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the port |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench targets the points where a masked port usually goes wrong.

A write with a partial or empty mask must leave the unmasked pins alone. A design that ignored the mask would clobber neighbouring outputs. Reads mix output and input pins under a mask, with pin_in set opposite to the driven values. This shows a wrong read source as flipped bits, and a missing mask as stray ones.

The synchronizer depth is checked edge by edge: a design with one stage or three would show the new level a cycle early or late. Offsets next to the direction register and above the data window are written and read. A decoder that ignored the high address bits would corrupt the direction or data registers there. A setup-only cycle is also issued, which catches a design that writes without penable.

// File: rtl/gpio_mp_pkg.sv
// Package: shared types and defaults for the address-masked GPIO port.
// Assumes: one data window at the bottom of the map, one direction word just above it.
package gpio_mp_pkg;

    // Default geometry of one port instance.
    localparam int unsigned DEF_PINS        = 8;
    localparam int unsigned DEF_ADDR_W      = 12;
    localparam int unsigned DEF_DATA_W      = 32;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Which register an access targets.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/gpio_mp_decode.sv
// Module: address decoder of the GPIO port.
// Classifies each bus access as data window, direction word or unmapped.
// Extracts the pin mask from the word address, and forms the write and read qualifiers.
// Assumes: the data window is every address whose bits above the mask are zero, and the
// direction word is the first word above that window.
module gpio_mp_decode
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NPINS  = DEF_PINS,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output acc_kind_e         kind,
    output logic [NPINS-1:0]  mask,
    output logic              wr_en,
    output logic              rd_en
);

    localparam int unsigned MASK_LO  = 2;
    localparam int unsigned MASK_HI  = NPINS + 1;
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned DIR_WORD = 1 << NPINS;

    logic [WORD_W-1:0] word_addr;
    logic              in_window;
    logic              unused_byte_lane;

    // Word address and pin mask taken straight from the bus address.
    assign word_addr        = paddr[ADDR_W-1:2];
    assign mask             = paddr[MASK_HI:MASK_LO];
    assign unused_byte_lane = ^paddr[1:0];

    // The data window needs every bit above the mask to be zero.
    assign in_window = (paddr[ADDR_W-1:MASK_HI+1] == '0);

    // Classify the access target.
    always_comb begin
        if (in_window) begin
            kind = ACC_DATA;
        end else if (word_addr == DIR_WORD[WORD_W-1:0]) begin
            kind = ACC_DIR;
        end else begin
            kind = ACC_NONE;
        end
    end

    // Write only in the access phase. Read data is offered whenever a read is selected.
    assign wr_en = psel & penable & pwrite;
    assign rd_en = psel & ~pwrite;

endmodule

// File: rtl/gpio_mp_sync.sv
// Module: per-pin input synchronizer.
// Carries each pad level through a chain of flops clocked by the bus clock.
// Assumes: pad inputs are asynchronous and single-bit, so no bus coherency is needed.
module gpio_mp_sync #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_sync
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        // Shift the pad level one stage per clock; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else if (STAGES == 1) begin
                chain_q[0] <= pin_async[p];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_async[p]};
            end
        end

        assign pin_sync[p] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_mp_regs.sv
// Module: direction and output data registers of the GPIO port.
// The output register takes a per-bit masked write. The direction register takes a plain write.
// Assumes: wr_en is already qualified with the access phase.
module gpio_mp_regs
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NPINS = DEF_PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  acc_kind_e        kind,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q
);

    logic data_wr;
    logic dir_wr;

    // Target strobes.
    assign data_wr = wr_en && (kind == ACC_DATA);
    assign dir_wr  = wr_en && (kind == ACC_DIR);

    for (genvar b = 0; b < NPINS; b++) begin : g_bit
        // Output bit b: updated only when its mask bit selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q[b] <= 1'b0;
            end else if (data_wr && mask[b]) begin
                out_q[b] <= wdata[b];
            end
        end

        // Direction bit b: updated by any write to the direction word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q[b] <= 1'b0;
            end else if (dir_wr) begin
                dir_q[b] <= wdata[b];
            end
        end
    end

endmodule

// File: rtl/gpio_mp_rdpath.sv
// Module: read data path of the GPIO port.
// Picks each pin's live value, applies the address mask, and zero-extends to the bus width.
// Assumes: the read data is combinational and is sampled by the master in the access phase.
module gpio_mp_rdpath
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NPINS  = DEF_PINS,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              rd_en,
    input  acc_kind_e         kind,
    input  logic [NPINS-1:0]  mask,
    input  logic [NPINS-1:0]  dir_q,
    input  logic [NPINS-1:0]  out_q,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - NPINS;

    logic [NPINS-1:0] live;
    logic [NPINS-1:0] sel_val;

    // Each pin's live value: the driven value for outputs, the synchronized pad for inputs.
    for (genvar b = 0; b < NPINS; b++) begin : g_live
        assign live[b] = dir_q[b] ? out_q[b] : pin_sync[b];
    end

    // Choose the register image for this access.
    always_comb begin
        sel_val = '0;
        if (rd_en) begin
            unique case (kind)
                ACC_DATA: sel_val = live & mask;
                ACC_DIR:  sel_val = dir_q;
                default:  sel_val = '0;
            endcase
        end
    end

    assign rdata = {{PAD_W{1'b0}}, sel_val};

endmodule

// File: rtl/gpio_masked_port.sv
// Module: address-masked GPIO port, top level.
// An APB-style slave with no wait states and no error response. It holds a direction
// register and an output register with masked writes, and synchronizes the pad inputs.
// Assumes: one instance per group of NPINS pins. The bus clock also samples the pads.
module gpio_masked_port
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NPINS       = DEF_PINS,
    parameter int unsigned AW          = DEF_ADDR_W,
    parameter int unsigned DW          = DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    output logic             pready,
    output logic             pslverr,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);

    acc_kind_e        kind;
    logic [NPINS-1:0] mask;
    logic             wr_en;
    logic             rd_en;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] pin_sync;
    logic             unused_wdata_hi;

    // Upper write-data bits carry no register state.
    assign unused_wdata_hi = ^pwdata[DW-1:NPINS];

    // Classify the access and extract the mask.
    gpio_mp_decode #(
        .NPINS  (NPINS),
        .ADDR_W (AW)
    ) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .kind    (kind),
        .mask    (mask),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    // Bring the pads into the bus clock domain.
    gpio_mp_sync #(
        .NPINS  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (pclk),
        .rst_n     (presetn),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    // Hold the direction and output state.
    gpio_mp_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk   (pclk),
        .rst_n (presetn),
        .wr_en (wr_en),
        .kind  (kind),
        .mask  (mask),
        .wdata (pwdata[NPINS-1:0]),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    // Build the read data.
    gpio_mp_rdpath #(
        .NPINS  (NPINS),
        .DATA_W (DW)
    ) u_rdpath (
        .rd_en    (rd_en),
        .kind     (kind),
        .mask     (mask),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .pin_sync (pin_sync),
        .rdata    (prdata)
    );

    // Pad drive and fixed bus handshake.
    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_masked_port_chk.sv
// Module: protocol and register checker for the address-masked GPIO port.
// It sees only the top-level ports and is attached to every instance by the bind below.
module gpio_masked_port_chk #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned AW    = 12,
    parameter int unsigned DW    = 32
) (
    input logic             pclk,
    input logic             presetn,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [AW-1:0]    paddr,
    input logic [DW-1:0]    pwdata,
    input logic [DW-1:0]    prdata,
    input logic             pready,
    input logic             pslverr,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe
);

    localparam int unsigned DIR_WORD = 1 << NPINS;

    logic             acc_wr;
    logic             is_data;
    logic             is_dir;
    logic [NPINS-1:0] amask;
    logic [DW-1:0]    amask_ext;
    logic             unused_chk;

    // Decode the access from the ports, independently of the design.
    assign acc_wr     = psel && penable && pwrite;
    assign is_data    = (paddr[AW-1:NPINS+2] == '0);
    assign is_dir     = (paddr[AW-1:2] == DIR_WORD[AW-3:0]);
    assign amask      = paddr[NPINS+1:2];
    assign amask_ext  = {{(DW-NPINS){1'b0}}, amask};
    assign unused_chk = ^{pwdata[DW-1:NPINS], paddr[1:0]};

    AST_BUS_FIXED: assert property (@(posedge pclk) disable iff (!presetn) pready && !pslverr); // R10
    AST_RESET_CLEAR: assert property (@(posedge pclk) disable iff (!presetn) $past(!presetn) |-> (pin_out == '0) && (pin_oe == '0)); // R1
    AST_DIR_WRITE: assert property (@(posedge pclk) disable iff (!presetn) (acc_wr && is_dir) |=> (pin_oe == $past(pwdata[NPINS-1:0]))); // R2
    AST_MASK_KEEP: assert property (@(posedge pclk) disable iff (!presetn) (acc_wr && is_data) |=> (((pin_out ^ $past(pin_out)) & ~$past(amask)) == '0)); // R4
    AST_MASK_TAKE: assert property (@(posedge pclk) disable iff (!presetn) (acc_wr && is_data) |=> (((pin_out ^ $past(pwdata[NPINS-1:0])) & $past(amask)) == '0)); // R4
    AST_READ_MASKED: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && is_data) |-> ((prdata & ~amask_ext) == '0)); // R5
    AST_OUT_READBACK: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && is_data) |-> (((prdata[NPINS-1:0] ^ pin_out) & pin_oe & amask) == '0)); // R7
    AST_UNMAPPED_READ: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && !is_data && !is_dir) |-> (prdata == '0)); // R9
    AST_UNMAPPED_WRITE: assert property (@(posedge pclk) disable iff (!presetn) (acc_wr && !is_data && !is_dir) |=> $stable(pin_out) && $stable(pin_oe)); // R9
    AST_IDLE_HOLD: assert property (@(posedge pclk) disable iff (!presetn) !acc_wr |=> $stable(pin_out) && $stable(pin_oe)); // R11

endmodule

bind gpio_masked_port gpio_masked_port_chk #(
    .NPINS (NPINS),
    .AW    (AW),
    .DW    (DW)
) u_chk (.*);

// File: tb/gpio_masked_port_tb.sv
// Bench for the address-masked GPIO port: a vector table, then directed corner cases.
module gpio_masked_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 18;

    // Vector layout: [40] read, [39:28] addr, [27:20] wdata, [19:12] pin_in, [11:4] expect, [3:0] req.
    // A write is checked against pin_out (data window) or pin_oe (any other offset).
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 12'h400, 8'h0F, 8'h00, 8'h0F, 4'd2},  // R2 direction write
        {1'b1, 12'h400, 8'h00, 8'h00, 8'h0F, 4'd2},  // R2 direction readback
        {1'b0, 12'h3FC, 8'hA5, 8'h00, 8'hA5, 4'd3},  // R3 R4 full mask write
        {1'b0, 12'h00C, 8'hFF, 8'h00, 8'hA7, 4'd4},  // R4 mask 0x03
        {1'b0, 12'h020, 8'h08, 8'h00, 8'hAF, 4'd8},  // R8 pin 3 high
        {1'b0, 12'h020, 8'h00, 8'h00, 8'hA7, 4'd8},  // R8 pin 3 low
        {1'b0, 12'h000, 8'h00, 8'h00, 8'hA7, 4'd4},  // R4 empty mask
        {1'b1, 12'h3FC, 8'h00, 8'hF0, 8'hF7, 4'd6},  // R6 mixed read
        {1'b1, 12'h3FC, 8'h00, 8'h0F, 8'h07, 4'd7},  // R7 outputs ignore pads
        {1'b1, 12'h0C0, 8'h00, 8'hFF, 8'h30, 4'd5},  // R5 partial mask
        {1'b1, 12'h040, 8'h00, 8'h00, 8'h00, 4'd8},  // R8 pin 4 read low
        {1'b1, 12'h010, 8'h00, 8'h00, 8'h04, 4'd8},  // R8 pin 2 read
        {1'b0, 12'h800, 8'hFF, 8'h00, 8'h0F, 4'd9},  // R9 write above window
        {1'b1, 12'h800, 8'h00, 8'hFF, 8'h00, 4'd9},  // R9 read above window
        {1'b0, 12'h404, 8'hFF, 8'h00, 8'h0F, 4'd9},  // R9 write beside dir
        {1'b1, 12'h404, 8'h00, 8'h00, 8'h00, 4'd9},  // R9 read beside dir
        {1'b0, 12'hC00, 8'h00, 8'h00, 8'h0F, 4'd9},  // R9 write top
        {1'b1, 12'h3FC, 8'h00, 8'h00, 8'h07, 4'd7}   // R7 state kept
    };

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    gpio_masked_port u_dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = {24'h0, d};
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R10 handshake", {30'h0, pready, pslverr}, 32'h2);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge pclk);
        // R1 reset state
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        presetn = 1'b1;
        apb_read(12'h400, rd);
        check("R1 dir read", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            @(negedge pclk);
            pin_in = v[19:12];
            repeat (3) @(negedge pclk);
            if (v[40]) begin
                apb_read(v[39:28], rd);
                check(tag, rd, {24'h0, v[11:4]});
            end else begin
                apb_write(v[39:28], v[27:20]);
                if (v[39:38] == 2'b00) check(tag, {24'h0, pin_out}, {24'h0, v[11:4]});
                else check(tag, {24'h0, pin_oe}, {24'h0, v[11:4]});
            end
        end

        // R3 pin_out drives the register value even for input pins
        check("R3 pin_out", {24'h0, pin_out}, 32'hA7);
        check("R3 pin_oe", {24'h0, pin_oe}, 32'h0F);

        // R6 synchronizer depth on input pin 7 (offset 0x200 selects it alone)
        @(negedge pclk);
        pin_in = 8'h00;
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h200;
        repeat (3) @(negedge pclk);
        pin_in = 8'h80;
        #1 check("R6 before edge", prdata, 32'h0);
        @(negedge pclk);
        #1 check("R6 one edge", prdata, 32'h0);
        @(negedge pclk);
        #1 check("R6 two edges", prdata, 32'h80);
        @(negedge pclk);
        psel = 1'b0;

        // R11 setup phase alone does not write
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 32'h0;
        @(negedge pclk);
        psel = 1'b0;
        @(negedge pclk);
        check("R11 setup only", {24'h0, pin_out}, 32'hA7);
        // R11 penable without psel does not write
        penable = 1'b1; pwrite = 1'b1; paddr = 12'h400;
        @(negedge pclk);
        penable = 1'b0; pwrite = 1'b0;
        @(negedge pclk);
        check("R11 no select", {24'h0, pin_oe}, 32'h0F);

        // R1 reset in mid-run clears state
        presetn = 1'b0;
        @(negedge pclk);
        check("R1 mid reset out", {24'h0, pin_out}, 32'h0);
        check("R1 mid reset oe", {24'h0, pin_oe}, 32'h0);
        presetn = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule